// File: doc/BRIEF.md
# Two-Channel Serial Pattern Generator

The block drives two independent serial outputs, each made of a data line and a companion clock line. Each channel holds a pattern of up to 64 bits in two 32-bit words, together with a bit count, a repeat count and a clock divider. When its enable is set, the channel shifts the pattern out least-significant bit first, once per period of its output clock. It repeats the whole pattern the programmed number of times and then signals completion.

Each channel has its own clock polarity. The polarity sets the idle level of the clock line, and with it the clock edge on which data moves. A completion event sets a sticky interrupt bit for that channel, which is cleared by writing 1. Each interrupt bit is masked by its own enable bit before it reaches the interrupt output. Clearing a channel's enable while a pattern is in flight abandons the rest of that pattern at once. The configuration inputs are expected to stay stable while a channel runs.

Top module: `pattern_gen2`

## Requirements
- R1: The two channels run independently and at the same time. Each has its own enable, polarity, divider, pattern words, length and repeat count (channel c uses slice c of each vector).
- R2: With divider value N, the running clock line keeps its idle level for the first N+1 cycles and then toggles every N+1 cycles, giving a period of 2*(N+1) system cycles.
- R3: With length value L, each repetition sends L+1 bits, least-significant first. Bit indices 0..31 are taken from bits 0..31 of the low word, and indices 32..63 from bits 0..31 of the high word.
- R4: With repeat value R, the pattern is sent R+1 times. The run lasts 2*(N+1)*(L+1)*(R+1) cycles, counted from the first running cycle up to and including the cycle of the completion pulse.
- R5: While running, the clock line equals the internal phase XOR polarity. The data line changes only when the clock line returns to its idle level: on the falling edge when polarity is 0, on the rising edge when polarity is 1.
- R6: The completion pulse is high for exactly one cycle, the last running cycle. Afterwards the channel stays finished (clock at idle level, data low, no pulse) until its enable is cleared.
- R7: A disabled or finished channel holds its clock line at the polarity value and its data line at 0.
- R8: Clearing enable while running returns the channel to idle in the next cycle with no completion pulse. A later re-enable starts again from bit 0 of the first repetition.
- R9: The interrupt state bit of channel c (bit c) is set in the cycle after that channel's completion pulse. A 1 on the matching clear bit resets it, and a completion in the same cycle as a clear leaves the bit set.
- R10: The interrupt output bit c equals interrupt state bit c AND interrupt enable bit c.
- R11: During and right after reset, both data lines, completion pulses and interrupt state bits are 0, and each clock line equals its polarity input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NUM_CH | Per-channel enable; starts a run while idle, aborts a run when cleared |
| ch_pol | input | NUM_CH | Per-channel clock polarity and idle clock level |
| ch_prediv | input | NUM_CH*DIV_W | Per-channel divider value N |
| ch_data_lo | input | NUM_CH*32 | Per-channel pattern bits 0..31 |
| ch_data_hi | input | NUM_CH*32 | Per-channel pattern bits 32..63 |
| ch_len | input | NUM_CH*6 | Per-channel bit count minus one |
| ch_reps | input | NUM_CH*REP_W | Per-channel repetition count minus one |
| irq_enable | input | NUM_CH | Interrupt mask bits |
| irq_clear | input | NUM_CH | Write-1-to-clear pulses for the interrupt state |
| ser_clk | output | NUM_CH | Per-channel output clock line |
| ser_data | output | NUM_CH | Per-channel serial data line |
| done_event | output | NUM_CH | One-cycle completion pulse per channel |
| irq_state | output | NUM_CH | Sticky interrupt state bits |
| irq | output | NUM_CH | Masked interrupt outputs |

## Verification
The bench targets the minimum case of one bit, one repetition and divider 0. A design that is off by one in any of the three counters stretches this two-cycle run or loses it. A 64-bit pattern checks the move into the high word; taking the wrong bit index there corrupts the upper half of the pattern. Polarity 1 checks that the clock is inverted without moving the data edge. A clear that arrives in the same cycle as a completion checks priority; a design that lets the clear win drops an interrupt. An abort in mid-pattern followed by a re-enable checks that no stale completion pulse appears and that the divider phase does not carry into the new run.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = $clog2(2 * WORD_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ch_state_e;

  // Select pattern bit idx out of the concatenated low/high words.
  function automatic logic pick_bit(input logic [WORD_W-1:0] lo,
                                    input logic [WORD_W-1:0] hi,
                                    input logic [IDX_W-1:0]  idx);
    logic [2*WORD_W-1:0] whole;
    whole = {hi, lo};
    return whole[idx];
  endfunction

  // True when a counter sits on its terminal value.
  function automatic logic at_limit(input int unsigned cnt, input int unsigned lim);
    return cnt == lim;
  endfunction
endpackage

// File: rtl/pg_divider.sv
`timescale 1ns/1ps
module pg_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             phase,
  output logic             half_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;

  assign half_tick = run && pg_pkg::at_limit(int'(cnt), int'(limit));
  assign fall_tick = half_tick && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (half_tick) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit)); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_tick) |=> (phase == $past(phase))); // R2
endmodule

// File: rtl/pg_channel.sv
`timescale 1ns/1ps
module pg_channel #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned REP_W = 10,
  localparam int unsigned WW   = pg_pkg::WORD_W,
  localparam int unsigned LW   = pg_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic [DIV_W-1:0] prediv,
  input  logic [WW-1:0]    data_lo,
  input  logic [WW-1:0]    data_hi,
  input  logic [LW-1:0]    len,
  input  logic [REP_W-1:0] reps,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             done_event
);
  import pg_pkg::*;

  ch_state_e        state;
  logic [LW-1:0]    bit_cnt;
  logic [REP_W-1:0] rep_cnt;
  logic             run;
  logic             phase;
  logic             half_tick;
  logic             fall_tick;
  logic             bit_last;
  logic             rep_last;

  assign run      = (state == ST_RUN);
  assign bit_last = at_limit(int'(bit_cnt), int'(len));
  assign rep_last = at_limit(int'(rep_cnt), int'(reps));

  pg_divider #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .limit     (prediv),
    .phase     (phase),
    .half_tick (half_tick),
    .fall_tick (fall_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rep_cnt <= '0;
    end else if (!en) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rep_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          state   <= ST_RUN;
          bit_cnt <= '0;
          rep_cnt <= '0;
        end
        ST_RUN: begin
          if (fall_tick) begin
            if (bit_last) begin
              bit_cnt <= '0;
              if (rep_last) state <= ST_FIN;
              else          rep_cnt <= rep_cnt + 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_FIN;
      endcase
    end
  end

  assign done_event = run && en && fall_tick && bit_last && rep_last;
  assign ser_clk    = run ? (phase ^ pol) : pol;
  assign ser_data   = run ? pick_bit(data_lo, data_hi, bit_cnt) : 1'b0;

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_IDLE)); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_event |=> (state == ST_FIN)); // R6
  AST_FIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |-> (!done_event && !ser_data && (ser_clk == pol))); // R6
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_cnt <= len)); // R3
  AST_DATA_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(fall_tick)) |-> $stable(ser_data)); // R5
endmodule

// File: rtl/pg_irq.sv
`timescale 1ns/1ps
module pg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic state_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_o <= 1'b0;
    else if (event_i) state_o <= 1'b1;
    else if (clr_i)   state_o <= 1'b0;
  end

  assign irq_o = state_o & ie_i;

  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> state_o); // R9
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !event_i) |=> !state_o); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !event_i) |=> (state_o == $past(state_o))); // R9
endmodule

// File: rtl/pattern_gen2.sv
`timescale 1ns/1ps
module pattern_gen2 #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned REP_W  = 10,
  localparam int unsigned WW    = pg_pkg::WORD_W,
  localparam int unsigned LW    = pg_pkg::IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH-1:0]       ch_pol,
  input  logic [NUM_CH*DIV_W-1:0] ch_prediv,
  input  logic [NUM_CH*WW-1:0]    ch_data_lo,
  input  logic [NUM_CH*WW-1:0]    ch_data_hi,
  input  logic [NUM_CH*LW-1:0]    ch_len,
  input  logic [NUM_CH*REP_W-1:0] ch_reps,
  input  logic [NUM_CH-1:0]       irq_enable,
  input  logic [NUM_CH-1:0]       irq_clear,
  output logic [NUM_CH-1:0]       ser_clk,
  output logic [NUM_CH-1:0]       ser_data,
  output logic [NUM_CH-1:0]       done_event,
  output logic [NUM_CH-1:0]       irq_state,
  output logic [NUM_CH-1:0]       irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pg_channel #(.DIV_W(DIV_W), .REP_W(REP_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ch_en[c]),
      .pol        (ch_pol[c]),
      .prediv     (ch_prediv[c*DIV_W +: DIV_W]),
      .data_lo    (ch_data_lo[c*WW +: WW]),
      .data_hi    (ch_data_hi[c*WW +: WW]),
      .len        (ch_len[c*LW +: LW]),
      .reps       (ch_reps[c*REP_W +: REP_W]),
      .ser_clk    (ser_clk[c]),
      .ser_data   (ser_data[c]),
      .done_event (done_event[c])
    );

    pg_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (done_event[c]),
      .clr_i   (irq_clear[c]),
      .ie_i    (irq_enable[c]),
      .state_o (irq_state[c]),
      .irq_o   (irq[c])
    );
  end

  always_comb begin
    AST_IRQ_MASKED: assert (((irq & ~irq_enable) == '0) || !rst_n); // R10
  end
endmodule

// File: tb/pattern_gen2_test.sv
`timescale 1ns/1ps
module pattern_gen2_test;
  localparam int NC = 2;
  localparam int DW = 16;
  localparam int RW = 10;
  localparam int LW = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     ch_en = '0;
  logic [NC-1:0]     ch_pol = '0;
  logic [NC*DW-1:0]  ch_prediv = '0;
  logic [NC*32-1:0]  ch_data_lo = '0;
  logic [NC*32-1:0]  ch_data_hi = '0;
  logic [NC*LW-1:0]  ch_len = '0;
  logic [NC*RW-1:0]  ch_reps = '0;
  logic [NC-1:0]     irq_enable = '0;
  logic [NC-1:0]     irq_clear = '0;
  logic [NC-1:0]     ser_clk, ser_data, done_event, irq_state, irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit mon_on   = 1'b0;

  pattern_gen2 #(.NUM_CH(NC), .DIV_W(DW), .REP_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_pol(ch_pol),
    .ch_prediv(ch_prediv), .ch_data_lo(ch_data_lo), .ch_data_hi(ch_data_hi),
    .ch_len(ch_len), .ch_reps(ch_reps), .irq_enable(irq_enable),
    .irq_clear(irq_clear), .ser_clk(ser_clk), .ser_data(ser_data),
    .done_event(done_event), .irq_state(irq_state), .irq(irq)
  );

  always #10 clk = ~clk; // 50 MHz

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  function automatic int cfg_n(input int c); return int'(ch_prediv[c*DW +: DW]); endfunction
  function automatic int cfg_l(input int c); return int'(ch_len[c*LW +: LW]); endfunction
  function automatic int cfg_r(input int c); return int'(ch_reps[c*RW +: RW]); endfunction

  function automatic int total_cycles(input int n, input int l, input int r);
    return 2 * (n + 1) * (l + 1) * (r + 1);
  endfunction

  function automatic bit exp_clk(input bit pol, input int n, input int k);
    return pol ^ bit'((k / (n + 1)) % 2);
  endfunction

  function automatic bit exp_data(input logic [31:0] lo, input logic [31:0] hi,
                                  input int n, input int l, input int k);
    int idx;
    idx = (k / (2 * (n + 1))) % (l + 1);
    return (idx < 32) ? lo[idx] : hi[idx - 32];
  endfunction

  // Model: 0 idle, 1 running, 2 finished
  int mst [NC];
  int mk  [NC];
  bit mirq[NC];

  always begin
    logic [NC-1:0] en_s, clr_s;
    @(posedge clk);
    en_s  = ch_en;
    clr_s = irq_clear;
    #5;
    if (!mon_on) begin
      for (int c = 0; c < NC; c++) begin mst[c] = 0; mk[c] = 0; mirq[c] = 0; end
    end else begin
      for (int c = 0; c < NC; c++) begin
        int  t;
        bit  fired;
        bit  pol;
        t     = total_cycles(cfg_n(c), cfg_l(c), cfg_r(c));
        fired = (mst[c] == 1) && (mk[c] == t - 1) && en_s[c];
        if (fired) mirq[c] = 1'b1;
        else if (clr_s[c]) mirq[c] = 1'b0;
        if (!en_s[c]) mst[c] = 0;
        else if (mst[c] == 0) begin mst[c] = 1; mk[c] = 0; end
        else if (mst[c] == 1) begin
          if (fired) mst[c] = 2;
          else mk[c] = mk[c] + 1;
        end
        pol = ch_pol[c];
        if (mst[c] == 1) begin
          chk(ser_clk[c] == exp_clk(pol, cfg_n(c), mk[c]), "R2", "ser_clk running",
              int'(ser_clk[c]), int'(exp_clk(pol, cfg_n(c), mk[c])));
          chk(ser_data[c] == exp_data(ch_data_lo[c*32 +: 32], ch_data_hi[c*32 +: 32],
                                      cfg_n(c), cfg_l(c), mk[c]),
              "R3", "ser_data running", int'(ser_data[c]),
              int'(exp_data(ch_data_lo[c*32 +: 32], ch_data_hi[c*32 +: 32],
                            cfg_n(c), cfg_l(c), mk[c])));
        end else begin
          chk(ser_clk[c] == pol, "R7", "ser_clk idle", int'(ser_clk[c]), int'(pol));
          chk(ser_data[c] == 1'b0, "R7", "ser_data idle", int'(ser_data[c]), 0);
        end
        chk(done_event[c] == ((mst[c] == 1) && (mk[c] == t - 1) && en_s[c]), "R6",
            "done_event", int'(done_event[c]),
            int'((mst[c] == 1) && (mk[c] == t - 1) && en_s[c]));
        chk(irq_state[c] == mirq[c], "R9", "irq_state", int'(irq_state[c]), int'(mirq[c]));
        chk(irq[c] == (mirq[c] & irq_enable[c]), "R10", "irq", int'(irq[c]),
            int'(mirq[c] & irq_enable[c]));
      end
    end
  end

  task automatic set_cfg(input int c, input int n, input int l, input int r,
                         input bit pol, input logic [31:0] lo, input logic [31:0] hi);
    ch_prediv[c*DW +: DW]  = DW'(n);
    ch_len[c*LW +: LW]     = LW'(l);
    ch_reps[c*RW +: RW]    = RW'(r);
    ch_pol[c]              = pol;
    ch_data_lo[c*32 +: 32] = lo;
    ch_data_hi[c*32 +: 32] = hi;
  endtask

  // Enable a channel and count cycles up to and including its completion pulse.
  task automatic run_to_done(input int c, output int cyc);
    cyc = 0;
    @(negedge clk);
    ch_en[c] = 1'b1;
    while (cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (done_event[c]) break;
    end
  endtask

  task automatic finish_ch(input int c);
    @(negedge clk);
    irq_clear[c] = 1'b1;
    ch_en[c]     = 1'b0;
    @(negedge clk);
    irq_clear[c] = 1'b0;
    @(negedge clk);
  endtask

  task automatic directed(input int c, input int n, input int l, input int r, input bit pol,
                          input logic [31:0] lo, input logic [31:0] hi);
    int cyc;
    set_cfg(c, n, l, r, pol, lo, hi);
    run_to_done(c, cyc);
    chk(cyc == total_cycles(n, l, r), "R4", "run length", cyc, total_cycles(n, l, r));
    repeat (3) @(negedge clk);
    finish_ch(c);
  endtask

  initial begin
    #(20 * 150000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int cyc0, cyc1;
    void'($urandom(32'd2024));
    ch_pol = 2'b10;
    #35;
    // R11: outputs while held in reset
    chk(ser_data == '0, "R11", "ser_data in reset", int'(ser_data), 0);
    chk(ser_clk == ch_pol, "R11", "ser_clk in reset", int'(ser_clk), int'(ch_pol));
    chk(irq_state == '0, "R11", "irq_state in reset", int'(irq_state), 0);
    chk(done_event == '0, "R11", "done in reset", int'(done_event), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    chk(irq_state == '0, "R11", "irq_state after reset", int'(irq_state), 0);
    ch_pol = '0;
    irq_enable = 2'b01;

    // Minimum: one bit, one repetition, divider 0
    directed(0, 0, 0, 0, 1'b0, 32'h1, 32'h0);
    // Full 64-bit pattern crossing into the high word
    directed(0, 1, 63, 0, 1'b0, 32'hA5C3_0F81, 32'h7E19_D24B);
    // Inverted clock polarity, several repetitions
    irq_enable = 2'b10;
    directed(1, 2, 7, 2, 1'b1, 32'h0000_00B6, 32'h0);

    // R9: clear arriving together with completion keeps the bit set
    set_cfg(0, 0, 3, 1, 1'b0, 32'h9, 32'h0);
    run_to_done(0, cyc0);
    irq_clear[0] = 1'b1;
    @(negedge clk);
    irq_clear[0] = 1'b0;
    chk(irq_state[0] == 1'b1, "R9", "set beats clear", int'(irq_state[0]), 1);
    finish_ch(0);

    // R1: both channels at once with different settings
    irq_enable = 2'b11;
    set_cfg(0, 1, 12, 2, 1'b0, 32'hDEAD_BEEF, 32'h0);
    set_cfg(1, 0, 40, 1, 1'b1, 32'h1234_5678, 32'hCAFE_F00D);
    fork
      run_to_done(0, cyc0);
      run_to_done(1, cyc1);
    join
    chk(cyc0 == total_cycles(1, 12, 2), "R1", "ch0 length concurrent", cyc0, total_cycles(1, 12, 2));
    chk(cyc1 == total_cycles(0, 40, 1), "R1", "ch1 length concurrent", cyc1, total_cycles(0, 40, 1));
    @(negedge clk);
    @(negedge clk);
    chk(irq_state == 2'b11, "R1", "both irq bits", int'(irq_state), 3);
    finish_ch(0);
    finish_ch(1);

    // R8: abort mid-pattern, then restart with a fresh configuration
    set_cfg(1, 3, 50, 3, 1'b0, 32'hFFFF_0000, 32'h0F0F_0F0F);
    @(negedge clk);
    ch_en[1] = 1'b1;
    repeat (37) @(negedge clk);
    ch_en[1] = 1'b0;
    repeat (6) @(negedge clk);
    chk(irq_state[1] == 1'b0, "R8", "no irq after abort", int'(irq_state[1]), 0);
    chk(ser_data[1] == 1'b0, "R8", "data low after abort", int'(ser_data[1]), 0);
    directed(1, 1, 9, 1, 1'b0, 32'h0000_02D5, 32'h0);

    // Constrained random runs
    for (int it = 0; it < 16; it++) begin
      int c, n, l, r, cyc;
      bit pol;
      c   = int'($urandom_range(1, 0));
      n   = int'($urandom_range(3, 0));
      l   = int'($urandom_range(63, 0));
      r   = int'($urandom_range(3, 0));
      pol = bit'($urandom_range(1, 0));
      irq_enable = NC'($urandom_range(3, 0));
      set_cfg(c, n, l, r, pol, $urandom(), $urandom());
      run_to_done(c, cyc);
      chk(cyc == total_cycles(n, l, r), "R4", "random run length", cyc, total_cycles(n, l, r));
      repeat (2) @(negedge clk);
      finish_ch(c);
    end

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule